// File: doc/BRIEF.md
# Shift-Register Video Timing Generator

This block produces the raster timing for a display pipe: horizontal and vertical sync, a display-enable window, and markers for the first pixel of each line and of each frame. It does not count pixels and lines with binary adders. Each axis holds a 16-bit linear feedback shift register. The register advances by one shift per step, and every timing event is found by an equality compare against a programmed register state. The carry chain of a wide counter is replaced by one XOR of four taps, so the logic in the pixel clock domain stays shallow.

Software turns a desired step count k into a register value. It does this by running the same shift sequence k times from the all-ones state. Position k of an axis is therefore "the state after k steps". A pixel-clock enable paces the raster. A two-bit blank control can blank the picture, or it can power the output down entirely.

Top module: `lfsr_video_timing`

## Requirements
- R1: While reset is held and after its release, both axis registers sit at 16'hFFFF (position 0): line_start and frame_start are high, hsync is low for a start position other than 0, and de is low.
- R2: One step moves state s to {s[14:0], s[15]^s[4]^s[2]^s[1]}. Position k of an axis is the state reached after k steps from 16'hFFFF. Every programmed value is such a state and is matched by equality.
- R3: On an enabled cycle where the horizontal register equals h_end, it reloads to 16'hFFFF. A line therefore lasts (steps of h_end)+1 enabled cycles, and line_start is high exactly at horizontal position 0.
- R4: The vertical register steps once on each horizontal reload. It reloads to 16'hFFFF when a horizontal reload happens while it equals v_end, so a frame is (steps of v_end)+1 lines.
- R5: hsync is high at horizontal positions from the h_sync_on match up to, but not including, the h_sync_off match.
- R6: vsync is high at vertical positions from the v_sync_on match up to, but not including, the v_sync_off match.
- R7: de is high only when the horizontal position lies in [h_act_on, h_act_off) and the vertical position lies in [v_act_on, v_act_off), both taken as match positions.
- R8: When pix_en is low, neither axis advances and no output changes.
- R9: blank_mode 2'b01 forces de low while hsync, vsync and the counters keep running.
- R10: blank_mode 2'b10 or 2'b11 (power-down) forces de, hsync and vsync low, and the counters keep running.
- R11: frame_start is high only when both axes are at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel step enable |
| blank_mode | input | 2 | 00 run, 01 blank, 1x power-down |
| h_act_on | input | 16 | Horizontal display start state |
| h_act_off | input | 16 | Horizontal display end state |
| h_end | input | 16 | Last horizontal position state |
| h_sync_on | input | 16 | Horizontal sync start state |
| h_sync_off | input | 16 | Horizontal sync end state |
| v_act_on | input | 16 | Vertical display start state |
| v_act_off | input | 16 | Vertical display end state |
| v_end | input | 16 | Last vertical position state |
| v_sync_on | input | 16 | Vertical sync start state |
| v_sync_off | input | 16 | Vertical sync end state |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Display enable |
| line_start | output | 1 | High at horizontal position 0 |
| frame_start | output | 1 | High at position 0 of both axes |

## Verification
The bench follows the raster as plain integer positions and turns its programmed values into shift states with its own step routine. Every cycle it compares the outputs with that integer model. A design that compared binary counts, or that used the wrong taps, would put sync and display edges at wrong positions. An off-by-one at a reload would stretch each line or frame by one. Windows that close at their end match are checked at both edges, so an inclusive end would widen hsync, vsync and de by one. The bench also checks that a low enable freezes the raster, and that each blank code keeps or drops the syncs as required. A reset in mid-frame must bring the raster back to position 0.

// File: rtl/lfsr_video_timing.sv
module lfsr_video_timing #(
  parameter int W = 16,
  parameter logic [W-1:0] SEED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pix_en,
  input  logic [1:0]   blank_mode,
  input  logic [W-1:0] h_act_on,
  input  logic [W-1:0] h_act_off,
  input  logic [W-1:0] h_end,
  input  logic [W-1:0] h_sync_on,
  input  logic [W-1:0] h_sync_off,
  input  logic [W-1:0] v_act_on,
  input  logic [W-1:0] v_act_off,
  input  logic [W-1:0] v_end,
  input  logic [W-1:0] v_sync_on,
  input  logic [W-1:0] v_sync_off,
  output logic         hsync,
  output logic         vsync,
  output logic         de,
  output logic         line_start,
  output logic         frame_start
);

  function automatic logic [W-1:0] lfsr_next(input logic [W-1:0] s);
    return {s[W-2:0], s[W-1] ^ s[4] ^ s[2] ^ s[1]};
  endfunction

  logic [W-1:0] hc, vc;
  logic hs_q, vs_q, ha_q, va_q;
  logic h_wrap, v_wrap;
  logic hs_win, vs_win, ha_win, va_win;
  logic pwr_down, blanked;

  assign h_wrap = (hc == h_end);
  assign v_wrap = (vc == v_end);

  // Window open from the start match, closed at the end match
  assign hs_win = ((hc == h_sync_on) | hs_q) & (hc != h_sync_off);
  assign ha_win = ((hc == h_act_on)  | ha_q) & (hc != h_act_off);
  assign vs_win = ((vc == v_sync_on) | vs_q) & (vc != v_sync_off);
  assign va_win = ((vc == v_act_on)  | va_q) & (vc != v_act_off);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc   <= SEED;
      vc   <= SEED;
      hs_q <= 1'b0;
      ha_q <= 1'b0;
      vs_q <= 1'b0;
      va_q <= 1'b0;
    end else if (pix_en) begin
      hs_q <= hs_win;
      ha_q <= ha_win;
      if (h_wrap) begin
        hc   <= SEED;
        vs_q <= vs_win;
        va_q <= va_win;
        vc   <= v_wrap ? SEED : lfsr_next(vc);
      end else begin
        hc <= lfsr_next(hc);
      end
    end
  end

  assign pwr_down    = blank_mode[1];
  assign blanked     = |blank_mode;
  assign hsync       = hs_win & ~pwr_down;
  assign vsync       = vs_win & ~pwr_down;
  assign de          = ha_win & va_win & ~blanked;
  assign line_start  = (hc == SEED);
  assign frame_start = line_start & (vc == SEED);

  p_h_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en && h_wrap |=> line_start);
  p_v_only_on_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en && !h_wrap |=> $stable(vc));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> $stable(hc) && $stable(vc));
  p_blank_de_r9: assert property (@(posedge clk) disable iff (!rst_n)
    blank_mode != 2'b00 |-> !de);
  p_pwrdown_sync_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> !hsync && !vsync);

endmodule

// File: tb/test_lfsr_video_timing.sv
module test_lfsr_video_timing;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pix_en = 1'b0;
  logic [1:0] blank_mode = 2'b00;
  logic [15:0] h_act_on, h_act_off, h_end, h_sync_on, h_sync_off;
  logic [15:0] v_act_on, v_act_off, v_end, v_sync_on, v_sync_off;
  logic hsync, vsync, de, line_start, frame_start;

  always #4 clk = ~clk;

  lfsr_video_timing i_lfsr_video_timing (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .blank_mode(blank_mode),
    .h_act_on(h_act_on), .h_act_off(h_act_off), .h_end(h_end),
    .h_sync_on(h_sync_on), .h_sync_off(h_sync_off),
    .v_act_on(v_act_on), .v_act_off(v_act_off), .v_end(v_end),
    .v_sync_on(v_sync_on), .v_sync_off(v_sync_off),
    .hsync(hsync), .vsync(vsync), .de(de),
    .line_start(line_start), .frame_start(frame_start)
  );

  // Raster in integer positions: 10 pixels per line, 6 lines per frame
  localparam int HN = 10, VN = 6;
  localparam int HS0 = 1, HS1 = 3, HA0 = 4, HA1 = 8;
  localparam int VS0 = 0, VS1 = 2, VA0 = 3, VA1 = 5;

  // Vector: cycles[15:0], blank_mode[17:16], enable kind[19:18] (0 on, 1 alternate, 2 off)
  localparam int NV = 8;
  localparam logic [19:0] VEC [NV] = '{
    {2'd0, 2'b00, 16'd130},
    {2'd1, 2'b00, 16'd70},
    {2'd2, 2'b00, 16'd20},
    {2'd0, 2'b01, 16'd70},
    {2'd0, 2'b10, 16'd70},
    {2'd2, 2'b11, 16'd10},
    {2'd0, 2'b11, 16'd70},
    {2'd0, 2'b00, 16'd65}
  };

  int checks = 0, fails = 0;
  int hp = 0, vp = 0;
  bit done = 1'b0;

  function automatic logic [15:0] pos_state(input int k);
    logic [15:0] s = 16'hFFFF;
    for (int i = 0; i < k; i++) s = {s[14:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
    return s;
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at h=%0d v=%0d: got %b expected %b", tag, hp, vp, act, exp);
    end
  endtask

  task automatic check_all(input logic [1:0] m);
    check(hsync, !m[1] && hp >= HS0 && hp < HS1, "R5/R10 hsync");
    check(vsync, !m[1] && vp >= VS0 && vp < VS1, "R6/R10 vsync");
    check(de, m == 2'b00 && hp >= HA0 && hp < HA1 && vp >= VA0 && vp < VA1, "R7/R9 de");
    check(line_start, hp == 0, "R3 line_start");
    check(frame_start, hp == 0 && vp == 0, "R11/R4 frame_start");
  endtask

  // One cycle: drive at negedge, check, let the edge pass, advance the model (R2 R8)
  task automatic cycle(input logic en, input logic [1:0] m);
    @(negedge clk);
    pix_en = en;
    blank_mode = m;
    #1;
    check_all(m);
    @(posedge clk);
    if (en) begin
      if (hp == HN - 1) begin
        hp = 0;
        vp = (vp == VN - 1) ? 0 : vp + 1;
      end else begin
        hp++;
      end
    end
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    h_end = pos_state(HN - 1);
    h_sync_on = pos_state(HS0);  h_sync_off = pos_state(HS1);
    h_act_on = pos_state(HA0);   h_act_off = pos_state(HA1);
    v_end = pos_state(VN - 1);
    v_sync_on = pos_state(VS0);  v_sync_off = pos_state(VS1);
    v_act_on = pos_state(VA0);   v_act_off = pos_state(VA1);

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(line_start, 1'b1, "R1 line_start in reset");
    check(frame_start, 1'b1, "R1 frame_start in reset");
    check(hsync, 1'b0, "R1 hsync in reset");
    check(de, 1'b0, "R1 de in reset");
    rst_n = 1'b1;

    // Vector table: R2..R11 every cycle
    for (int v = 0; v < NV; v++) begin
      for (int c = 0; c < int'(VEC[v][15:0]); c++) begin
        logic en;
        case (VEC[v][19:18])
          2'd0: en = 1'b1;
          2'd1: en = (c % 2 == 0);
          default: en = 1'b0;
        endcase
        cycle(en, VEC[v][17:16]);
      end
    end

    // R1: reset in mid-frame returns to position 0
    while (!(hp == 5 && vp == 4)) cycle(1'b1, 2'b00);
    @(negedge clk);
    rst_n = 1'b0;
    pix_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    pix_en = 1'b0;
    #1;
    hp = 0;
    vp = 0;
    check(frame_start, 1'b1, "R1 frame_start after mid-frame reset");
    check(de, 1'b0, "R1 de after mid-frame reset");
    rst_n = 1'b1;
    // R2/R3: a full frame after reset lines up with the model
    for (int c = 0; c < HN * VN + 3; c++) cycle(1'b1, 2'b00);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule